// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers single-cycle event pulses from the master and slave engines of a bus controller and drives one interrupt line. Each engine has a sticky status register and an enable mask. A status bit is set by an event pulse and stays set until software writes a 1 to it.

Above the two engines sits a summary register with one bit per engine. It shows which engine has an enabled event pending. It has its own enable mask and its own write-one-to-clear. The interrupt line is the registered OR of the enabled summary bits.

Software reaches every register through a plain word interface: address, write data, write strobe and read data. Reads are combinational from the address, and a write takes effect on the clock edge where the strobe is sampled.

Top module: `irq_tree`

## Requirements
- R1: After reset every status register, every enable register and `irq_o` read as zero.
- R2: A pulse on `mst_evt_i[i]` sets bit 4+i of the master status (address 0x4C; bits 4..13 are implemented). The bit stays set until it is cleared by software.
- R3: Writing the master status address clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set. Clears of other bits in that write still take effect.
- R5: A pulse on `slv_evt_i[i]` sets bit i of the slave status (address 0x74). These bits are sticky and are cleared by writing 1.
- R6: The enable registers store written data masked to their implemented bits:
  - master enable at 0x48, bits 13..4;
  - slave enable at 0x70, bits 7..0;
  - summary enable at 0x08, bits 1..0.
- R7: The summary status (address 0x04) reads bit 0 as 1 whenever master status AND master enable is non-zero. It reads bit 1 as 1 whenever the same holds for the slave registers. This remains true right after a write of 1 to that summary bit.
- R8: A summary bit that was raised stays set after its engine's enabled status goes to zero. It clears only when software writes a 1 to it.
- R9: `irq_o` goes high one clock after (summary status AND summary enable) becomes non-zero. It goes low one clock after that AND becomes zero.
- R10: Reading any address other than 0x04, 0x08, 0x48, 0x4C, 0x70 or 0x74 returns zero. A write to such an address changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for `addr_i` |
| mst_evt_i | input | 10 | Master engine event pulses, index i maps to status bit 4+i |
| slv_evt_i | input | 8 | Slave engine event pulses, index i maps to status bit i |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a summary bit that is latched while nothing beneath it is pending any more. Reaching it takes an event, an enable, a clearing write at the engine level, and then a read of the summary before software acknowledges it. The stimulus builds this up in order: it enables one master bit and pulses it, enables a slave bit, then clears both engine statuses and shows that the summary still reads as set. The same-cycle collision between a pulse and a clearing write is also hard to hit by chance. It is created by driving the event and the write strobe on the same clock edge, with the write also clearing several other bits.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned M_EVT  = 10;
  localparam int unsigned M_LSB  = 4;
  localparam int unsigned S_EVT  = 8;
  localparam int unsigned S_LSB  = 0;
  localparam int unsigned N_SRC  = 2;

  localparam logic [ADDR_W-1:0] A_TOP_ST = 8'h04;
  localparam logic [ADDR_W-1:0] A_TOP_EN = 8'h08;
  localparam logic [ADDR_W-1:0] A_M_EN   = 8'h48;
  localparam logic [ADDR_W-1:0] A_M_ST   = 8'h4C;
  localparam logic [ADDR_W-1:0] A_S_EN   = 8'h70;
  localparam logic [ADDR_W-1:0] A_S_ST   = 8'h74;

  typedef enum logic [0:0] {SRC_MST = 1'b0, SRC_SLV = 1'b1} src_e;

  typedef struct packed {
    logic top_st;
    logic top_en;
    logic m_st;
    logic m_en;
    logic s_st;
    logic s_en;
  } wr_sel_t;
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         st_clr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] wfield_i,
  output logic [N-1:0] st_o,
  output logic [N-1:0] en_o,
  output logic         pend_o
);
  logic [N-1:0] st_q, en_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    // a new pulse wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       st_q[b] <= 1'b0;
      else if (evt_i[b])                 st_q[b] <= 1'b1;
      else if (st_clr_i && wfield_i[b])  st_q[b] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_q[b] <= 1'b0;
      else if (en_wr_i) en_q[b] <= wfield_i[b];
    end
  end

  assign st_o   = st_q;
  assign en_o   = en_q;
  assign pend_o = |(st_q & en_q);
endmodule

// File: rtl/irq_src_summary.sv
module irq_src_summary #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic             st_clr_i,
  input  logic             en_wr_i,
  input  logic [N_SRC-1:0] wfield_i,
  output logic [N_SRC-1:0] st_o,
  output logic [N_SRC-1:0] en_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] lat_q, en_q;
  logic             irq_q;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       lat_q[s] <= 1'b0;
      else if (pend_i[s])                lat_q[s] <= 1'b1;
      else if (st_clr_i && wfield_i[s])  lat_q[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= wfield_i;
  end

  // live pending shows through without waiting for the latch
  assign st_o = lat_q | pend_i;
  assign en_o = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(st_o & en_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_tree_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [M_EVT-1:0]  m_st_i,
  input  logic [M_EVT-1:0]  m_en_i,
  input  logic [S_EVT-1:0]  s_st_i,
  input  logic [S_EVT-1:0]  s_en_i,
  input  logic [N_SRC-1:0]  t_st_i,
  input  logic [N_SRC-1:0]  t_en_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_TOP_ST: rdata_o[N_SRC-1:0]     = t_st_i;
      A_TOP_EN: rdata_o[N_SRC-1:0]     = t_en_i;
      A_M_ST:   rdata_o[M_LSB +: M_EVT] = m_st_i;
      A_M_EN:   rdata_o[M_LSB +: M_EVT] = m_en_i;
      A_S_ST:   rdata_o[S_LSB +: S_EVT] = s_st_i;
      A_S_EN:   rdata_o[S_LSB +: S_EVT] = s_en_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_tree.sv
module irq_tree
  import irq_tree_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [M_EVT-1:0]  mst_evt_i,
  input  logic [S_EVT-1:0]  slv_evt_i,
  output logic              irq_o
);
  wr_sel_t          wsel;
  logic [M_EVT-1:0] m_st, m_en;
  logic [S_EVT-1:0] s_st, s_en;
  logic [N_SRC-1:0] t_st, t_en, pend;
  logic             unused_wdata;

  assign wsel.top_st = we_i && (addr_i == A_TOP_ST);
  assign wsel.top_en = we_i && (addr_i == A_TOP_EN);
  assign wsel.m_st   = we_i && (addr_i == A_M_ST);
  assign wsel.m_en   = we_i && (addr_i == A_M_EN);
  assign wsel.s_st   = we_i && (addr_i == A_S_ST);
  assign wsel.s_en   = we_i && (addr_i == A_S_EN);
  assign unused_wdata = ^wdata_i;

  irq_evt_bank #(.N(M_EVT)) i_mst_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (mst_evt_i),
    .st_clr_i (wsel.m_st),
    .en_wr_i  (wsel.m_en),
    .wfield_i (wdata_i[M_LSB +: M_EVT]),
    .st_o     (m_st),
    .en_o     (m_en),
    .pend_o   (pend[SRC_MST])
  );

  irq_evt_bank #(.N(S_EVT)) i_slv_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (slv_evt_i),
    .st_clr_i (wsel.s_st),
    .en_wr_i  (wsel.s_en),
    .wfield_i (wdata_i[S_LSB +: S_EVT]),
    .st_o     (s_st),
    .en_o     (s_en),
    .pend_o   (pend[SRC_SLV])
  );

  irq_src_summary #(.N_SRC(N_SRC)) i_summary (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .st_clr_i (wsel.top_st),
    .en_wr_i  (wsel.top_en),
    .wfield_i (wdata_i[N_SRC-1:0]),
    .st_o     (t_st),
    .en_o     (t_en),
    .irq_o    (irq_o)
  );

  irq_rd_mux i_rd_mux (
    .addr_i  (addr_i),
    .m_st_i  (m_st),
    .m_en_i  (m_en),
    .s_st_i  (s_st),
    .s_en_i  (s_en),
    .t_st_i  (t_st),
    .t_en_i  (t_en),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk
  import irq_tree_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [M_EVT-1:0]  mst_evt_i,
  input logic [S_EVT-1:0]  slv_evt_i,
  input logic              irq_o,
  input logic [M_EVT-1:0]  m_st,
  input logic [M_EVT-1:0]  m_en,
  input logic [S_EVT-1:0]  s_st,
  input logic [S_EVT-1:0]  s_en,
  input logic [N_SRC-1:0]  t_st,
  input logic [N_SRC-1:0]  t_en
);
  logic mapped;
  assign mapped = (addr_i == A_TOP_ST) || (addr_i == A_TOP_EN) ||
                  (addr_i == A_M_ST)   || (addr_i == A_M_EN)   ||
                  (addr_i == A_S_ST)   || (addr_i == A_S_EN);

  // R2 and R4: a pulse always lands, even against a clear
  p_mst_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_evt_i != '0) |=> ((m_st & $past(mst_evt_i)) == $past(mst_evt_i)));

  p_mst_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_M_ST) |=> (($past(m_st) & ~m_st) == '0));

  p_slv_evt_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_evt_i != '0) |=> ((s_st & $past(slv_evt_i)) == $past(slv_evt_i)));

  p_slv_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_S_ST) |=> (($past(s_st) & ~s_st) == '0));

  p_mst_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((m_st & m_en) != '0) |-> t_st[0]);

  p_slv_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s_st & s_en) != '0) |-> t_st[1]);

  p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((t_st & t_en) != '0) |=> irq_o);

  p_irq_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((t_st & t_en) == '0) |=> !irq_o);

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (rdata_o == '0));
endmodule

bind irq_tree irq_tree_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .rdata_o   (rdata_o),
  .mst_evt_i (mst_evt_i),
  .slv_evt_i (slv_evt_i),
  .irq_o     (irq_o),
  .m_st      (m_st),
  .m_en      (m_en),
  .s_st      (s_st),
  .s_en      (s_en),
  .t_st      (t_st),
  .t_en      (t_en)
);

// File: tb/test_irq_tree.sv
module test_irq_tree;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [9:0]  mevt = '0;
  logic [7:0]  sevt = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  irq_tree i_irq_tree (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .we_i      (we),
    .rdata_o   (rdata),
    .mst_evt_i (mevt),
    .slv_evt_i (sevt),
    .irq_o     (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse_m(input logic [9:0] m);
    @(negedge clk); mevt = m;
    @(negedge clk); mevt = '0;
  endtask

  task automatic pulse_s(input logic [7:0] m);
    @(negedge clk); sevt = m;
    @(negedge clk); sevt = '0;
  endtask

  task automatic t_reset;
    rd_chk(8'h04, 32'h0, "R1 top status");
    rd_chk(8'h08, 32'h0, "R1 top enable");
    rd_chk(8'h48, 32'h0, "R1 master enable");
    rd_chk(8'h4C, 32'h0, "R1 master status");
    rd_chk(8'h70, 32'h0, "R1 slave enable");
    rd_chk(8'h74, 32'h0, "R1 slave status");
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_master_sticky;
    pulse_m(10'h001);
    rd_chk(8'h4C, 32'h0000_0010, "R2 single bit");
    repeat (5) @(negedge clk);
    rd_chk(8'h4C, 32'h0000_0010, "R2 held");
    pulse_m(10'h3FF);
    rd_chk(8'h4C, 32'h0000_3FF0, "R2 all bits");
  endtask

  task automatic t_w1c;
    wr(8'h4C, 32'h0000_0010);
    rd_chk(8'h4C, 32'h0000_3FE0, "R3 clear one");
    wr(8'h4C, 32'h0);
    rd_chk(8'h4C, 32'h0000_3FE0, "R3 zero write");
    wr(8'h4C, 32'hFFFF_FFFF);
    rd_chk(8'h4C, 32'h0, "R3 clear all");
  endtask

  task automatic t_priority;
    pulse_m(10'h00F);
    rd_chk(8'h4C, 32'h0000_00F0, "R4 setup");
    @(negedge clk);
    addr = 8'h4C; wdata = 32'h0000_3FF0; we = 1'b1; mevt = 10'h200;
    @(negedge clk);
    we = 1'b0; wdata = '0; mevt = '0;
    rd_chk(8'h4C, 32'h0000_2000, "R4 pulse wins");
    wr(8'h4C, 32'h0000_2000);
    rd_chk(8'h4C, 32'h0, "R4 cleanup");
  endtask

  task automatic t_slave;
    pulse_s(8'hA5);
    rd_chk(8'h74, 32'h0000_00A5, "R5 set");
    repeat (3) @(negedge clk);
    rd_chk(8'h74, 32'h0000_00A5, "R5 held");
    wr(8'h74, 32'h0000_0005);
    rd_chk(8'h74, 32'h0000_00A0, "R5 partial clear");
    wr(8'h74, 32'h0000_00FF);
    rd_chk(8'h74, 32'h0, "R5 clear all");
  endtask

  task automatic t_enables;
    wr(8'h48, 32'hFFFF_FFFF);
    rd_chk(8'h48, 32'h0000_3FF0, "R6 master mask");
    wr(8'h70, 32'hFFFF_FFFF);
    rd_chk(8'h70, 32'h0000_00FF, "R6 slave mask");
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h0000_0003, "R6 top mask");
    wr(8'h48, 32'h0); wr(8'h70, 32'h0); wr(8'h08, 32'h0);
    rd_chk(8'h48, 32'h0, "R6 master zero");
  endtask

  task automatic t_summary;
    wr(8'h48, 32'h0000_0010);
    pulse_m(10'h001);
    rd_chk(8'h04, 32'h0000_0001, "R7 master pending");
    pulse_s(8'h04);
    rd_chk(8'h04, 32'h0000_0001, "R7 slave masked");
    wr(8'h70, 32'h0000_0004);
    rd_chk(8'h04, 32'h0000_0003, "R7 both pending");
    wr(8'h04, 32'h0000_0003);
    rd_chk(8'h04, 32'h0000_0003, "R7 ack while live");
  endtask

  task automatic t_top_sticky;
    wr(8'h4C, 32'h0000_0010);
    wr(8'h74, 32'h0000_0004);
    rd_chk(8'h04, 32'h0000_0003, "R8 latched");
    wr(8'h04, 32'h0000_0001);
    rd_chk(8'h04, 32'h0000_0002, "R8 ack master");
    wr(8'h04, 32'h0000_0002);
    rd_chk(8'h04, 32'h0, "R8 ack slave");
    wr(8'h70, 32'h0);
  endtask

  task automatic t_irq;
    wr(8'h08, 32'h0000_0001);
    chk("R9 idle", {31'b0, irq}, 32'h0);
    @(negedge clk); mevt = 10'h001;
    @(negedge clk); mevt = '0;
    chk("R9 not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 raised", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0);
    chk("R9 still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unmapped;
    rd_chk(8'h00, 32'h0, "R10 read 00");
    rd_chk(8'h0C, 32'h0, "R10 read 0C");
    rd_chk(8'h4D, 32'h0, "R10 read 4D");
    rd_chk(8'hFF, 32'h0, "R10 read FF");
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h4C, 32'h0000_0010, "R10 master status kept");
    rd_chk(8'h48, 32'h0000_0010, "R10 master enable kept");
    rd_chk(8'h08, 32'h0, "R10 top enable kept");
    rd_chk(8'h70, 32'h0, "R10 slave enable kept");
    rd_chk(8'h74, 32'h0, "R10 slave status kept");
    @(negedge clk);
    chk("R10 irq kept", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_master_sticky;
    t_w1c;
    t_priority;
    t_slave;
    t_enables;
    t_summary;
    t_top_sticky;
    t_irq;
    t_unmapped;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule